// File: doc/BRIEF.md
# Indirect Register Pointer Controller

This block is the host-facing register access unit of a two-channel serial controller whose host side offers only a control port per channel. The host reaches every control register through one indirection step. A control write made while a channel's pointer is zero is a command byte. Its low three bits name the next register to reach. Its middle three bits carry a command code, and one of those codes moves the selection into the upper bank of registers 8 to 15. Its top two bits carry a reset code. The next control access on that channel, read or write, reaches the named register, and the pointer then falls back to zero.

The block keeps one pointer per channel and turns each command and reset code into a single-clock strobe for the datapath around it. It stores the write registers. Two of them (2 and 9) are one copy seen from both channels. When a channel's enhanced-enable bit is set, register 7 is replaced by an alternate register. The block also builds the read data. Some read addresses show status that comes in on input ports, one address exists on channel A only, and register 15 reads back with two bits masked. Serial data, interrupt logic and clock generation sit outside and only use the strobes and register contents.

Top module: `dual_chan_regptr`

## Requirements
- R1: After reset both pointers are 0. Every write register, both alternate registers and all strobes are 0.
- R2: A control write while the channel's pointer is 0 loads the pointer from bits 2:0. If bits 5:3 equal 1 (point-high), 8 is added. A select of 0 without point-high leaves the pointer at 0.
- R3: A control access (read or write) while the pointer is nonzero reaches the register at the pointer, and the pointer returns to 0. The two channels' pointers are independent.
- R4: Command codes 2 to 7 in bits 5:3 of a register-0 write raise `cmd_pulse[ch*8+code]` (ch 0 = A, 1 = B) for exactly the one clock after the write. Codes 0 and 1 raise no strobe.
- R5: A nonzero reset code in bits 7:6 of a register-0 write raises `rst_pulse[ch*4+code]` for one clock. It may come together with any command code.
- R6: Write registers 2 and 9 are a single copy. A write through either channel shows in byte 2 or 9 of both `wreg_a` and `wreg_b`, and reading through either channel returns it.
- R7: Read address 0 returns the channel's `stat0` input and address 1 returns its `stat1` input. Address 3 returns `ipend_a` on channel A and 0x00 on channel B. Address 2 returns the shared register 2 on channel A and `vecstat_b` on channel B.
- R8: Read address 15 returns write register 15 with bits 2 and 0 forced to 0.
- R9: While bit 0 of a channel's write register 15 is 1, a write to register 7 goes to that channel's alternate register (`alt7_*`) and leaves register 7 unchanged. Read address 14 returns the alternate register. While the bit is 0, the write goes to register 7.
- R10: Read addresses 4 to 13 return the write register of the same number. Address 9 is the shared copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Control-port access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_chan | input | 1 | Channel addressed (0 = A, 1 = B) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed channel's current pointer |
| stat0_a | input | 8 | Channel A status for read address 0 |
| stat0_b | input | 8 | Channel B status for read address 0 |
| stat1_a | input | 8 | Channel A status for read address 1 |
| stat1_b | input | 8 | Channel B status for read address 1 |
| ipend_a | input | 8 | Pending summary, read address 3 of channel A |
| vecstat_b | input | 8 | Vector with status, read address 2 of channel B |
| wreg_a | output | 128 | Channel A write registers, byte n = register n (byte 0 is 0) |
| wreg_b | output | 128 | Channel B write registers, same layout |
| alt7_a | output | 8 | Channel A alternate register 7 |
| alt7_b | output | 8 | Channel B alternate register 7 |
| cmd_pulse | output | 16 | Command strobes, bit ch*8+code |
| rst_pulse | output | 8 | Reset-code strobes, bit ch*4+code |

## Verification
A wrong pointer shows at the very next control access on that channel. A write lands in the wrong byte of `wreg_*`, or a read returns the wrong source on `acc_rdata`. Either is visible in the same cycle as the access, or in the cycle after it. A wrong shared-register copy shows as byte 2 or 9 differing between the two channel views right after the write. A wrong decode shows as a strobe on the wrong bit, or as a strobe that is missing or lasts more than one clock, in the cycle after the command write.

// File: rtl/dual_chan_regptr_pkg.sv
package dual_chan_regptr_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 16;
    localparam int NCH     = 2;
    localparam int AW      = $clog2(NREG);
    localparam int CMDW    = 3;
    localparam int NCMD    = 1 << CMDW;
    localparam int RSTW    = 2;
    localparam int NRST    = 1 << RSTW;

    localparam int REG_SHARED_LO = 2;
    localparam int REG_SHARED_HI = 9;
    localparam int REG_ALT_WR    = 7;
    localparam int REG_ALT_RD    = 14;
    localparam int REG_EXT_EN    = 15;
    localparam int REG_PEND      = 3;
    localparam int EXT_EN_BIT    = 0;
    localparam logic [DW-1:0] RD15_MASK = 8'hFA;

    typedef enum logic [CMDW-1:0] {
        CMD_NONE      = 3'd0,
        CMD_POINT_HI  = 3'd1,
        CMD_CLR_EXT   = 3'd2,
        CMD_ABORT     = 3'd3,
        CMD_RX_NEXT   = 3'd4,
        CMD_CLR_TXINT = 3'd5,
        CMD_CLR_ERR   = 3'd6,
        CMD_CLR_IUS   = 3'd7
    } cmd_e;
endpackage

// File: rtl/regptr_chan.sv
module regptr_chan
    import dual_chan_regptr_pkg::*;
#(
    parameter int P_DW = DW,
    parameter int P_AW = AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic [P_DW-1:0] wdata,
    output logic [P_AW-1:0] ptr_o,
    output logic            reg_we,
    output logic [NCMD-1:0] cmd_pulse_o,
    output logic [NRST-1:0] rst_pulse_o
);
    localparam int HI_OFS = 1 << (P_AW - 1);

    typedef struct packed {
        logic [P_AW-1:0] ptr;
        logic [NCMD-1:0] cmd;
        logic [NRST-1:0] rst;
    } state_t;

    state_t st_d, st_q;
    cmd_e   code;
    logic [RSTW-1:0] rcode;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;
        st_d.rst = '0;
        reg_we   = 1'b0;
        code     = cmd_e'(wdata[5:3]);
        rcode    = wdata[7:6];
        if (sel) begin
            if (st_q.ptr == '0) begin
                if (wr) begin
                    st_d.ptr = P_AW'(wdata[2:0]) +
                               ((code == CMD_POINT_HI) ? P_AW'(HI_OFS) : '0);
                    if (code != CMD_NONE && code != CMD_POINT_HI)
                        st_d.cmd[code] = 1'b1;
                    if (rcode != '0)
                        st_d.rst[rcode] = 1'b1;
                end
            end else begin
                st_d.ptr = '0;
                reg_we   = wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o       = st_q.ptr;
    assign cmd_pulse_o = st_q.cmd;
    assign rst_pulse_o = st_q.rst;
endmodule

// File: rtl/regptr_bank.sv
module regptr_bank
    import dual_chan_regptr_pkg::*;
#(
    parameter int P_DW   = DW,
    parameter int P_NREG = NREG,
    parameter int P_AW   = AW
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCH-1:0]                    we,
    input  logic [NCH-1:0][P_AW-1:0]          ptr,
    input  logic [P_DW-1:0]                   wdata,
    output logic [NCH-1:0][P_NREG-1:0][P_DW-1:0] view_o,
    output logic [NCH-1:0][P_DW-1:0]          alt_o
);
    typedef struct packed {
        logic [NCH-1:0][P_NREG-1:0][P_DW-1:0] own;
        logic [P_DW-1:0]                      sh_lo;
        logic [P_DW-1:0]                      sh_hi;
        logic [NCH-1:0][P_DW-1:0]             alt;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int c = 0; c < NCH; c++) begin
            if (we[c]) begin
                if (ptr[c] == P_AW'(REG_SHARED_LO))
                    bk_d.sh_lo = wdata;
                else if (ptr[c] == P_AW'(REG_SHARED_HI))
                    bk_d.sh_hi = wdata;
                else if (ptr[c] == P_AW'(REG_ALT_WR) &&
                         bk_q.own[c][REG_EXT_EN][EXT_EN_BIT])
                    bk_d.alt[c] = wdata;
                else
                    bk_d.own[c][ptr[c]] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < P_NREG; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign view_o[c][r] = '0;
            end else if (r == REG_SHARED_LO) begin : g_slo
                assign view_o[c][r] = bk_q.sh_lo;
            end else if (r == REG_SHARED_HI) begin : g_shi
                assign view_o[c][r] = bk_q.sh_hi;
            end else begin : g_own
                assign view_o[c][r] = bk_q.own[c][r];
            end
        end
        assign alt_o[c] = bk_q.alt[c];
    end
endmodule

// File: rtl/regptr_rdmux.sv
module regptr_rdmux
    import dual_chan_regptr_pkg::*;
#(
    parameter int P_DW   = DW,
    parameter int P_NREG = NREG,
    parameter int P_AW   = AW
) (
    input  logic                                 chan,
    input  logic [NCH-1:0][P_AW-1:0]             ptr,
    input  logic [NCH-1:0][P_NREG-1:0][P_DW-1:0] view,
    input  logic [NCH-1:0][P_DW-1:0]             alt,
    input  logic [NCH-1:0][P_DW-1:0]             stat0,
    input  logic [NCH-1:0][P_DW-1:0]             stat1,
    input  logic [P_DW-1:0]                      ipend,
    input  logic [P_DW-1:0]                      vecstat,
    output logic [P_DW-1:0]                      rdata
);
    logic [P_AW-1:0] a;

    always_comb begin
        a = ptr[chan];
        unique case (int'(a))
            0:             rdata = stat0[chan];
            1:             rdata = stat1[chan];
            REG_SHARED_LO: rdata = chan ? vecstat : view[0][REG_SHARED_LO];
            REG_PEND:      rdata = chan ? '0 : ipend;
            REG_ALT_RD:    rdata = alt[chan];
            REG_EXT_EN:    rdata = view[chan][REG_EXT_EN] & RD15_MASK;
            default:       rdata = view[chan][a];
        endcase
    end
endmodule

// File: rtl/dual_chan_regptr.sv
module dual_chan_regptr
    import dual_chan_regptr_pkg::*;
#(
    parameter int P_DW   = DW,
    parameter int P_NREG = NREG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic                   acc_chan,
    input  logic [P_DW-1:0]        acc_wdata,
    output logic [P_DW-1:0]        acc_rdata,
    input  logic [P_DW-1:0]        stat0_a,
    input  logic [P_DW-1:0]        stat0_b,
    input  logic [P_DW-1:0]        stat1_a,
    input  logic [P_DW-1:0]        stat1_b,
    input  logic [P_DW-1:0]        ipend_a,
    input  logic [P_DW-1:0]        vecstat_b,
    output logic [P_NREG*P_DW-1:0] wreg_a,
    output logic [P_NREG*P_DW-1:0] wreg_b,
    output logic [P_DW-1:0]        alt7_a,
    output logic [P_DW-1:0]        alt7_b,
    output logic [NCH*NCMD-1:0]    cmd_pulse,
    output logic [NCH*NRST-1:0]    rst_pulse
);
    localparam int L_AW = $clog2(P_NREG);

    logic [NCH-1:0][L_AW-1:0]             chan_ptr;
    logic [NCH-1:0]                       chan_we;
    logic [NCH-1:0][P_NREG-1:0][P_DW-1:0] view;
    logic [NCH-1:0][P_DW-1:0]             alt;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        regptr_chan #(.P_DW(P_DW), .P_AW(L_AW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (acc_valid && (acc_chan == 1'(c))),
            .wr         (acc_write),
            .wdata      (acc_wdata),
            .ptr_o      (chan_ptr[c]),
            .reg_we     (chan_we[c]),
            .cmd_pulse_o(cmd_pulse[c*NCMD +: NCMD]),
            .rst_pulse_o(rst_pulse[c*NRST +: NRST])
        );
    end

    regptr_bank #(.P_DW(P_DW), .P_NREG(P_NREG), .P_AW(L_AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (chan_we),
        .ptr   (chan_ptr),
        .wdata (acc_wdata),
        .view_o(view),
        .alt_o (alt)
    );

    regptr_rdmux #(.P_DW(P_DW), .P_NREG(P_NREG), .P_AW(L_AW)) u_rd (
        .chan   (acc_chan),
        .ptr    (chan_ptr),
        .view   (view),
        .alt    (alt),
        .stat0  ({stat0_b, stat0_a}),
        .stat1  ({stat1_b, stat1_a}),
        .ipend  (ipend_a),
        .vecstat(vecstat_b),
        .rdata  (acc_rdata)
    );

    assign wreg_a = view[0];
    assign wreg_b = view[1];
    assign alt7_a = alt[0];
    assign alt7_b = alt[1];
endmodule

// File: rtl/dual_chan_regptr_chk.sv
module dual_chan_regptr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_chan,
    input logic [7:0]  acc_wdata,
    input logic [7:0]  acc_rdata,
    input logic [1:0][3:0] ptr,
    input logic [15:0] cmd_pulse,
    input logic [7:0]  rst_pulse
);
    assert_ptr_back_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_chan && ptr[0] != 4'd0) |=> (ptr[0] == 4'd0));
    assert_ptr_back_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_chan && ptr[1] != 4'd0) |=> (ptr[1] == 4'd0));
    assert_point_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_chan && ptr[0] == 4'd0 && acc_wdata[5:3] == 3'd1)
        |=> (ptr[0] == {1'b1, $past(acc_wdata[2:0])}));
    assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse[7:0]) && $onehot0(cmd_pulse[15:8]));
    assert_cmd_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_pulse[7:0]) |-> $past(acc_valid && acc_write && !acc_chan));
    assert_rst_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rst_pulse[3:0]) && $onehot0(rst_pulse[7:4]));
    assert_rd15_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ptr[acc_chan] == 4'd15)
        |-> (acc_rdata[2] == 1'b0 && acc_rdata[0] == 1'b0));
    assert_b3_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_chan && ptr[1] == 4'd3) |-> (acc_rdata == 8'h00));
endmodule

bind dual_chan_regptr dual_chan_regptr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_chan (acc_chan),
    .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata),
    .ptr      (chan_ptr),
    .cmd_pulse(cmd_pulse),
    .rst_pulse(rst_pulse)
);

// File: tb/dual_chan_regptr_tb_top.sv
`timescale 1ns/1ps
module dual_chan_regptr_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_chan = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic [7:0] stat0_a = 8'hA0, stat0_b = 8'hB0, stat1_a = 8'hA1, stat1_b = 8'hB1;
    logic [7:0] ipend_a = 8'h2D, vecstat_b = 8'h6E;
    logic [127:0] wreg_a, wreg_b;
    logic [7:0] alt7_a, alt7_b;
    logic [15:0] cmd_pulse;
    logic [7:0]  rst_pulse;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dual_chan_regptr dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_chan = ch; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic ch, output logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_chan = ch;
        #5 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [7:0] rb(input logic [127:0] v, input int r);
        return v[r*8 +: 8];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 wreg_a", wreg_a[31:0] | wreg_a[127:96], 0);
        chk("R1 wreg_b", wreg_b[31:0] | wreg_b[127:96], 0);
        chk("R1 alt", {alt7_a, alt7_b}, 0);
        chk("R1 pulses", {cmd_pulse, rst_pulse}, 0);
        rd(1'b0, d); chk("R1 R7 read A addr0", d, 8'hA0);
        rd(1'b1, d); chk("R7 read B addr0", d, 8'hB0);
    endtask

    task automatic t_basic();
        wr(1'b0, 8'h05); wr(1'b0, 8'h3C);
        chk("R2 R3 reg5 A", rb(wreg_a, 5), 8'h3C);
        wr(1'b0, 8'h77);
        chk("R4 cmd6 A", cmd_pulse, 16'h0040);
        chk("R5 rst1 A", rst_pulse, 8'h02);
        @(negedge clk);
        chk("R4 R5 one clock", {cmd_pulse, rst_pulse}, 0);
        wr(1'b0, 8'h11);
        chk("R9 reg7 normal", rb(wreg_a, 7), 8'h11);
        chk("R9 alt untouched", alt7_a, 0);
    endtask

    task automatic t_cmds();
        for (int c = 2; c < 8; c++) begin
            wr(1'b0, 8'(c << 3));
            chk("R4 cmd code A", cmd_pulse, 32'(1 << c));
        end
        wr(1'b0, 8'h00);
        chk("R4 null no pulse", {cmd_pulse, rst_pulse}, 0);
    endtask

    task automatic t_high();
        logic [7:0] d;
        wr(1'b0, 8'h0C);
        chk("R4 point-high no pulse", cmd_pulse, 0);
        wr(1'b0, 8'hAB);
        chk("R2 reg12 A", rb(wreg_a, 12), 8'hAB);
        wr(1'b0, 8'h0C); rd(1'b0, d);
        chk("R10 read 12", d, 8'hAB);
    endtask

    task automatic t_shared();
        logic [7:0] d;
        wr(1'b1, 8'h02); wr(1'b1, 8'h5A);
        chk("R6 reg2 via B seen A", rb(wreg_a, 2), 8'h5A);
        chk("R6 reg2 via B seen B", rb(wreg_b, 2), 8'h5A);
        wr(1'b0, 8'h09); wr(1'b0, 8'hC3);
        chk("R6 reg9 A", rb(wreg_a, 9), 8'hC3);
        chk("R6 reg9 B", rb(wreg_b, 9), 8'hC3);
        wr(1'b1, 8'h09); rd(1'b1, d);
        chk("R6 R10 read9 B", d, 8'hC3);
    endtask

    task automatic t_rdmap();
        logic [7:0] d;
        wr(1'b1, 8'h03); rd(1'b1, d); chk("R7 B addr3", d, 8'h00);
        wr(1'b0, 8'h03); rd(1'b0, d); chk("R7 A addr3", d, 8'h2D);
        wr(1'b1, 8'h02); rd(1'b1, d); chk("R7 B addr2", d, 8'h6E);
        wr(1'b0, 8'h02); rd(1'b0, d); chk("R7 A addr2", d, 8'h5A);
        wr(1'b1, 8'h01); rd(1'b1, d); chk("R7 B addr1", d, 8'hB1);
        rd(1'b1, d); chk("R3 ptr back B", d, 8'hB0);
    endtask

    task automatic t_enh();
        logic [7:0] d;
        wr(1'b0, 8'h0F); wr(1'b0, 8'hFF);
        chk("R8 wreg15", rb(wreg_a, 15), 8'hFF);
        wr(1'b0, 8'h0F); rd(1'b0, d); chk("R8 read15", d, 8'hFA);
        wr(1'b0, 8'h07); wr(1'b0, 8'h99);
        chk("R9 alt7 A", alt7_a, 8'h99);
        chk("R9 reg7 kept", rb(wreg_a, 7), 8'h11);
        wr(1'b0, 8'h0E); rd(1'b0, d); chk("R9 read14", d, 8'h99);
        wr(1'b1, 8'h07); wr(1'b1, 8'h44);
        chk("R9 B reg7", rb(wreg_b, 7), 8'h44);
        chk("R9 B alt", alt7_b, 8'h00);
    endtask

    task automatic t_indep();
        logic [7:0] d;
        wr(1'b0, 8'h04); wr(1'b1, 8'h04); wr(1'b1, 8'h22); wr(1'b0, 8'h33);
        chk("R3 B reg4", rb(wreg_b, 4), 8'h22);
        chk("R3 A reg4", rb(wreg_a, 4), 8'h33);
        wr(1'b1, 8'hE8);
        chk("R4 B cmd5", cmd_pulse, 16'h2000);
        chk("R5 B rst3", rst_pulse, 8'h80);
        rd(1'b1, d); chk("R2 sel0 keeps ptr", d, 8'hB0);
    endtask

    task automatic t_midreset();
        logic [7:0] d;
        wr(1'b0, 8'h05);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 regs cleared", rb(wreg_a, 5) | rb(wreg_b, 4), 0);
        rd(1'b0, d); chk("R1 ptr cleared", d, 8'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_cmds();
        t_high();
        t_shared();
        t_rdmap();
        t_enh();
        t_indep();
        t_midreset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule